// File: doc/BRIEF.md
# Thread-to-Warp Formation Sequencer

This block takes the extent of a thread block along three axes and cuts its threads into fixed-size warps. A one-cycle start pulse loads the three extents. The block then produces one warp descriptor per accepted transfer on a valid/ready output. Each descriptor carries:

- the warp number;
- the linear ID of the warp's first thread;
- a mask of the lanes that hold a real thread;
- the x, y and z coordinate of every lane.

The linear order is row-major: x changes fastest, then y, then z. A two-dimensional block is given with a z extent of 1. A one-dimensional block is given with y and z extents of 1. Every extent must be at least 1.

The lane coordinates come from a chain of wrap-around increments that starts at the first lane. No division is used. The last lane's successor becomes the first lane of the next warp. A one-cycle done pulse follows the acceptance of the final warp.

Top module: `warp_former`

## Requirements
- R1: While reset is held and in the first cycle after it, `desc_valid` and `done` are 0.
- R2: For every valid lane i of warp w, the linear ID is n = w*WARP_SIZE + i. Its coordinates are x = n mod dx, y = (n div dx) mod dy and z = n div (dx*dy).
- R3: Warps are numbered 0, 1, 2 in output order. `base_tid` equals `warp_idx`*WARP_SIZE.
- R4: One start produces exactly ceil(dx*dy*dz / WARP_SIZE) accepted descriptors.
- R5: Bit i of `lane_mask` is 1 exactly when `base_tid`+i is below dx*dy*dz. The mask is therefore all ones except in a partial last warp.
- R6: While `desc_valid` is 1 and `desc_ready` is 0, every descriptor output holds its value in the next cycle.
- R7: `done` is 1 for exactly the one cycle after the last descriptor is accepted, and `desc_valid` is 0 in that cycle.
- R8: A start pulse that arrives while descriptors are still pending is ignored. Its extents have no effect.
- R9: WARP_SIZE is a parameter. The defaults are 32 and a configuration of 16 behaves by the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load extents and begin sequencing |
| dim_x | input | DIM_W | Extent along x |
| dim_y | input | DIM_W | Extent along y |
| dim_z | input | DIM_W | Extent along z |
| desc_valid | output | 1 | A descriptor is presented |
| desc_ready | input | 1 | The consumer accepts the descriptor |
| warp_idx | output | 3*DIM_W | Warp number |
| base_tid | output | 3*DIM_W | Linear ID of lane 0 |
| lane_mask | output | WARP_SIZE | Lane holds a real thread |
| lane_x | output | WARP_SIZE*DIM_W | Per-lane x, lane i at bits i*DIM_W |
| lane_y | output | WARP_SIZE*DIM_W | Per-lane y, lane i at bits i*DIM_W |
| lane_z | output | WARP_SIZE*DIM_W | Per-lane z, lane i at bits i*DIM_W |
| done | output | 1 | One-cycle pulse after the final warp |

## Verification
The bench targets blocks whose thread count sits exactly on, just above and far below a warp boundary, including a single thread. An off-by-one in the last-warp test would emit an extra empty warp or drop a partial one. A wrong mask compare would expose lanes beyond the thread count.

Extents such as 5x3 and 7x5x3 make the x and y wraps fall in the middle of a warp and across warp boundaries. A chain that carries into the wrong axis, or that fails to carry the last lane into the next warp, would show wrong coordinates there.

Random back-pressure and a start pulse injected mid-run check the remaining cases. A design that advanced on valid alone would skip warps. A design that accepted the late start would change its extents and its warp count.

// File: rtl/warp_former.sv
module warp_former #(
  parameter int WARP_SIZE = 32,
  parameter int DIM_W = 8,
  localparam int TID_W = 3 * DIM_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [DIM_W-1:0]             dim_x,
  input  logic [DIM_W-1:0]             dim_y,
  input  logic [DIM_W-1:0]             dim_z,
  output logic                         desc_valid,
  input  logic                         desc_ready,
  output logic [TID_W-1:0]             warp_idx,
  output logic [TID_W-1:0]             base_tid,
  output logic [WARP_SIZE-1:0]         lane_mask,
  output logic [WARP_SIZE*DIM_W-1:0]   lane_x,
  output logic [WARP_SIZE*DIM_W-1:0]   lane_y,
  output logic [WARP_SIZE*DIM_W-1:0]   lane_z,
  output logic                         done
);
  logic             active, done_q;
  logic [DIM_W-1:0] ext_x, ext_y;
  logic [DIM_W-1:0] org_x, org_y, org_z;
  logic [TID_W-1:0] total, base, widx;
  logic [WARP_SIZE:0][DIM_W-1:0] cx, cy, cz;
  logic             last;

  assign cx[0] = org_x;
  assign cy[0] = org_y;
  assign cz[0] = org_z;

  for (genvar i = 0; i < WARP_SIZE; i++) begin : g_lane
    logic wrap_x, wrap_y;
    assign wrap_x = ({1'b0, cx[i]} + 1'b1) == {1'b0, ext_x};
    assign wrap_y = ({1'b0, cy[i]} + 1'b1) == {1'b0, ext_y};
    assign cx[i+1] = wrap_x ? '0 : cx[i] + 1'b1;
    assign cy[i+1] = wrap_x ? (wrap_y ? '0 : cy[i] + 1'b1) : cy[i];
    assign cz[i+1] = (wrap_x && wrap_y) ? cz[i] + 1'b1 : cz[i];
    assign lane_x[i*DIM_W +: DIM_W] = cx[i];
    assign lane_y[i*DIM_W +: DIM_W] = cy[i];
    assign lane_z[i*DIM_W +: DIM_W] = cz[i];
    assign lane_mask[i] = ({1'b0, base} + (TID_W+1)'(i)) < {1'b0, total};
  end

  assign last       = ({1'b0, base} + (TID_W+1)'(WARP_SIZE)) >= {1'b0, total};
  assign desc_valid = active;
  assign warp_idx   = widx;
  assign base_tid   = base;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done_q <= 1'b0;
      ext_x  <= '0;
      ext_y  <= '0;
      total  <= '0;
      base   <= '0;
      widx   <= '0;
      org_x  <= '0;
      org_y  <= '0;
      org_z  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          ext_x  <= dim_x;
          ext_y  <= dim_y;
          total  <= TID_W'(dim_x) * TID_W'(dim_y) * TID_W'(dim_z);
          base   <= '0;
          widx   <= '0;
          org_x  <= '0;
          org_y  <= '0;
          org_z  <= '0;
        end
      end else if (desc_ready) begin
        if (last) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          base  <= base + TID_W'(WARP_SIZE);
          widx  <= widx + 1'b1;
          org_x <= cx[WARP_SIZE];
          org_y <= cy[WARP_SIZE];
          org_z <= cz[WARP_SIZE];
        end
      end
    end
  end
endmodule

// File: rtl/warp_former_chk.sv
module warp_former_chk #(
  parameter int WARP_SIZE = 32,
  parameter int DIM_W = 8,
  localparam int TID_W = 3 * DIM_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 desc_valid,
  input logic                 desc_ready,
  input logic [TID_W-1:0]     warp_idx,
  input logic [TID_W-1:0]     base_tid,
  input logic [WARP_SIZE-1:0] lane_mask,
  input logic                 done
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(base_tid) && $stable(warp_idx) && $stable(lane_mask));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !desc_valid);

  p_mask_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> lane_mask[0] && (((lane_mask + 1'b1) & lane_mask) == '0));

  p_base_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> done || (base_tid == $past(base_tid) + TID_W'(WARP_SIZE)));

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> done || (warp_idx == $past(warp_idx) + 1'b1));
endmodule

bind warp_former warp_former_chk #(.WARP_SIZE(WARP_SIZE), .DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .warp_idx(warp_idx), .base_tid(base_tid), .lane_mask(lane_mask), .done(done));

// File: tb/test_warp_former.sv
module test_warp_former;
  logic clk = 0, rst_n = 0, start = 0, ready = 0;
  logic [7:0] dx = 1, dy = 1, dz = 1;
  always #2.5 clk = ~clk;

  logic v32, d32, v16, d16;
  logic [23:0] wi32, bt32, wi16, bt16;
  logic [31:0] m32;
  logic [15:0] m16;
  logic [255:0] x32, y32, z32;
  logic [127:0] x16, y16, z16;

  warp_former #(.WARP_SIZE(32), .DIM_W(8)) i_warp_former (
    .clk(clk), .rst_n(rst_n), .start(start), .dim_x(dx), .dim_y(dy), .dim_z(dz),
    .desc_valid(v32), .desc_ready(ready), .warp_idx(wi32), .base_tid(bt32),
    .lane_mask(m32), .lane_x(x32), .lane_y(y32), .lane_z(z32), .done(d32));

  warp_former #(.WARP_SIZE(16), .DIM_W(8)) i_warp_former_ws16 (
    .clk(clk), .rst_n(rst_n), .start(start), .dim_x(dx), .dim_y(dy), .dim_z(dz),
    .desc_valid(v16), .desc_ready(ready), .warp_idx(wi16), .base_tid(bt16),
    .lane_mask(m16), .lane_x(x16), .lane_y(y16), .lane_z(z16), .done(d16));

  int checks = 0, errors = 0;
  int ws[2] = '{32, 16};
  int m_act[2], m_done[2], m_base[2], m_tot[2], m_dx[2], m_dy[2];
  int cnt[2], pv[2], pr, pbt[2];

  task automatic chk(input bit ok, input string req, input int k, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ws=%0d %s: actual %0d expected %0d", req, ws[k], what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [1:0] vv;
    logic [47:0] bb;
    vv = {v16, v32};
    bb = {bt16, bt32};
    for (int k = 0; k < 2; k++) begin
      if (rst_n && vv[k] && ready) cnt[k]++;
      pv[k] = vv[k];
      pbt[k] = bb[k*24 +: 24];
    end
    pr = ready;
    for (int k = 0; k < 2; k++) begin
      m_done[k] = 0;
      if (!rst_n) m_act[k] = 0;
      else if (m_act[k] != 0) begin
        if (ready) begin
          if (m_base[k] + ws[k] >= m_tot[k]) begin m_act[k] = 0; m_done[k] = 1; end
          else m_base[k] += ws[k];
        end
      end else if (start) begin
        m_act[k] = 1; m_base[k] = 0;
        m_tot[k] = int'(dx) * int'(dy) * int'(dz);
        m_dx[k] = int'(dx); m_dy[k] = int'(dy);
      end
    end
  end

  task automatic cmp(input int k, input logic v, input logic d, input logic [23:0] wi,
                     input logic [23:0] bt, input logic [31:0] mk,
                     input logic [255:0] lx, input logic [255:0] ly, input logic [255:0] lz);
    chk(v == m_act[k][0], "R7 R8", k, "desc_valid", v, m_act[k]);
    chk(d == m_done[k][0], "R7", k, "done", d, m_done[k]);
    if (pv[k] != 0 && pr == 0)
      chk(v && int'(bt) == pbt[k], "R6", k, "held base_tid", bt, pbt[k]);
    if (m_act[k] != 0 && v) begin
      chk(int'(wi) == m_base[k] / ws[k], "R3", k, "warp_idx", wi, m_base[k] / ws[k]);
      chk(int'(bt) == m_base[k], "R3", k, "base_tid", bt, m_base[k]);
      for (int i = 0; i < ws[k]; i++) begin
        int n = m_base[k] + i;
        chk(mk[i] == (n < m_tot[k]), "R5", k, $sformatf("mask lane %0d", i), mk[i], n < m_tot[k]);
        if (n < m_tot[k]) begin
          chk(int'(lx[i*8 +: 8]) == n % m_dx[k], "R2", k, $sformatf("x lane %0d", i),
              lx[i*8 +: 8], n % m_dx[k]);
          chk(int'(ly[i*8 +: 8]) == (n / m_dx[k]) % m_dy[k], "R2", k, $sformatf("y lane %0d", i),
              ly[i*8 +: 8], (n / m_dx[k]) % m_dy[k]);
          chk(int'(lz[i*8 +: 8]) == n / (m_dx[k] * m_dy[k]), "R2", k, $sformatf("z lane %0d", i),
              lz[i*8 +: 8], n / (m_dx[k] * m_dy[k]));
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!v32 && !d32, "R1", 0, "valid/done in reset", {v32, d32}, 0);
      chk(!v16 && !d16, "R1", 1, "valid/done in reset", {v16, d16}, 0);
    end else begin
      cmp(0, v32, d32, wi32, bt32, m32, x32, y32, z32);
      cmp(1, v16, d16, wi16, bt16, {16'b0, m16}, {128'b0, x16}, {128'b0, y16}, {128'b0, z16});
    end
  end

  task automatic run(input int a, input int b, input int c, input int mode);
    @(negedge clk);
    cnt[0] = 0; cnt[1] = 0;
    dx = 8'(a); dy = 8'(b); dz = 8'(c);
    start = 1; ready = (mode == 0);
    @(negedge clk);
    start = 0;
    for (int n = 0; n < 5000; n++) begin
      ready = (mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      if (mode == 2 && n == 1) begin start = 1; dx = 3; dy = 1; dz = 1; end
      else start = 0;
      @(negedge clk);
      if (m_act[0] == 0 && m_act[1] == 0) break;
    end
    start = 0;
    for (int k = 0; k < 2; k++)
      chk(cnt[k] == (a * b * c + ws[k] - 1) / ws[k], k == 1 ? "R4 R9" : (mode == 2 ? "R4 R8" : "R4"),
          k, "warps accepted", cnt[k], (a * b * c + ws[k] - 1) / ws[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!v32 && !d32, "R1", 0, "idle after reset", {v32, d32}, 0);
    run(1, 1, 1, 0);
    run(32, 1, 1, 0);
    run(33, 1, 1, 0);
    run(5, 3, 1, 0);
    run(4, 2, 4, 1);
    run(7, 5, 3, 1);
    run(3, 3, 3, 1);
    run(16, 16, 4, 2);
    run(255, 1, 1, 1);
    run(17, 3, 2, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule